// File: doc/BRIEF.md
# Quarter-Rate Interval Timer with Wrapping Comparator

This block keeps a free-running 64-bit tick counter that advances once per clock and presents software with a slower view of it: the counter divided by four. A read strobe captures that quarter-rate view into a held output register, so a reader gets one consistent value that does not move under it.

An alarm is armed by writing a 32-bit compare value. The value is scaled by four and placed into the low 34 bits of the current tick count, keeping the upper tick bits as they are. If the resulting deadline lies less than a guard distance (1000 ticks by default) ahead of the present tick, it is moved one full 2^34-tick round later. When the tick count reaches the deadline, a level interrupt is raised. The interrupt stays high until an acknowledge pulse or a new compare write clears it. Until the first compare write after reset, the alarm is disarmed and never fires.

Top module: `qtick_interval_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `count_o`, `deadline_o` and `irq_o` read zero, and the internal tick count is zero.
- R2: The internal tick count rises by exactly one on every clock edge after reset is released.
- R3: A cycle with `rd_stb` high loads `count_o` with tick bits 33:2 of that cycle; it is visible after the edge. Without `rd_stb`, `count_o` holds its value.
- R4: A cycle with `cmp_we` high computes a candidate deadline. The candidate takes tick bits 63:34 from that cycle, places `cmp_wdata` in bits 33:2, and sets bits 1:0 to zero. If no wrap applies (R5), the candidate appears on `deadline_o` after the edge.
- R5: If the candidate is strictly less than the tick of the write cycle plus 1000, then 2^34 is added to it. A candidate equal to tick plus 1000 is not moved.
- R6: Before the first compare write after reset, `irq_o` never rises, even though the tick count passes the reset deadline of zero.
- R7: When the alarm is armed and the tick count equals `deadline_o` in some cycle, `irq_o` is high from the next cycle on and stays high.
- R8: An `irq_ack` pulse in a cycle with no compare write and no deadline hit lowers `irq_o` after the edge.
- R9: A compare write lowers `irq_o` after the edge and re-arms the alarm. This holds even when the old deadline is hit in that same cycle.
- R10: When `irq_ack` arrives in the very cycle the deadline is hit, the hit wins and `irq_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_stb | input | 1 | Capture the quarter-rate counter into `count_o` |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 32 | Compare value, in quarter-rate units |
| irq_ack | input | 1 | Clears a pending interrupt |
| count_o | output | 32 | Last captured quarter-rate counter value |
| deadline_o | output | 64 | Stored deadline in ticks |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle: a deadline hit with an acknowledge, and a deadline hit with a fresh compare write. The bench provokes each one by waiting until its own tick model equals the stored deadline. In that cycle it drives the acknowledge or the write. It then judges the result from `irq_o` and `deadline_o` one cycle later: the hit must win over the acknowledge, and the write must win over the hit. The guard boundary is checked separately. The bench issues writes on tick values that are multiples of four, so the candidate can land exactly on tick+1000 (no wrap) or four ticks short of it (wrap).

// File: rtl/qtick_pkg.sv
// Package qtick_pkg
// Shared sizing for the quarter-rate interval timer.
// Assumes the compare field plus the scale shift fits inside the tick width.
package qtick_pkg;
    localparam int TICK_W   = 64;   // internal tick counter width
    localparam int CMP_W    = 32;   // compare register width
    localparam int SCALE_SH = 2;    // visible rate = tick rate >> SCALE_SH
    localparam int GUARD    = 1000; // minimum lead of a fresh deadline
endpackage

// File: rtl/qtick_counter.sv
// Module qtick_counter
// Free-running tick counter plus a held snapshot of its quarter-rate view.
// Assumes a synchronous active-low reset; the snapshot loads on rd_stb only.
module qtick_counter #(
    parameter int TICK_W   = qtick_pkg::TICK_W,
    parameter int CMP_W    = qtick_pkg::CMP_W,
    parameter int SCALE_SH = qtick_pkg::SCALE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    output logic [TICK_W-1:0] tick,
    output logic [CMP_W-1:0]  snap
);
    localparam int TOP_BIT = CMP_W + SCALE_SH - 1;

    // Advance the tick count by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + TICK_W'(1);
    end

    // Capture the scaled-down view when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap <= '0;
        else if (rd_stb) snap <= tick[TOP_BIT:SCALE_SH];
    end
endmodule

// File: rtl/qtick_deadline_calc.sv
// Module qtick_deadline_calc
// Combinational deadline builder: splices the scaled compare value into the
// low bits of the current tick and pushes it one round later if too close.
// Assumes TICK_W > CMP_W + SCALE_SH.
module qtick_deadline_calc #(
    parameter int TICK_W   = qtick_pkg::TICK_W,
    parameter int CMP_W    = qtick_pkg::CMP_W,
    parameter int SCALE_SH = qtick_pkg::SCALE_SH,
    parameter int GUARD    = qtick_pkg::GUARD
) (
    input  logic [TICK_W-1:0] tick,
    input  logic [CMP_W-1:0]  wdata,
    output logic [TICK_W-1:0] deadline
);
    localparam int                SPLICE_W = CMP_W + SCALE_SH;
    localparam logic [TICK_W-1:0] ROUND    = TICK_W'(1) << SPLICE_W;

    logic [TICK_W-1:0] spliced;
    logic [TICK_W:0]   horizon;
    logic              too_close;

    // Form the candidate and compare against tick + guard without overflow.
    always_comb begin
        spliced   = {tick[TICK_W-1:SPLICE_W], wdata, {SCALE_SH{1'b0}}};
        horizon   = {1'b0, tick} + (TICK_W+1)'(GUARD);
        too_close = ({1'b0, spliced} < horizon);
        deadline  = too_close ? spliced + ROUND : spliced;
    end
endmodule

// File: rtl/qtick_alarm.sv
// Module qtick_alarm
// Holds the deadline, the armed flag and the level interrupt.
// Priority per cycle: compare write, then deadline hit, then acknowledge.
// Assumes the alarm is one-shot: a hit disarms it until the next write.
module qtick_alarm #(
    parameter int TICK_W = qtick_pkg::TICK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick,
    input  logic              cmp_we,
    input  logic [TICK_W-1:0] new_deadline,
    input  logic              irq_ack,
    output logic [TICK_W-1:0] deadline,
    output logic              irq,
    output logic              hit
);
    logic armed;

    // Detect the tick reaching an armed deadline.
    always_comb hit = armed && (tick == deadline);

    // Update deadline, arm state and interrupt with write > hit > ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline <= '0;
            armed    <= 1'b0;
            irq      <= 1'b0;
        end else if (cmp_we) begin
            deadline <= new_deadline;
            armed    <= 1'b1;
            irq      <= 1'b0;
        end else if (hit) begin
            armed    <= 1'b0;
            irq      <= 1'b1;
        end else if (irq_ack) begin
            irq      <= 1'b0;
        end
    end
endmodule

// File: rtl/qtick_interval_timer.sv
// Module qtick_interval_timer
// Top of the quarter-rate interval timer: tick counter, deadline builder and
// alarm. Assumes one clock domain and a synchronous active-low reset.
module qtick_interval_timer #(
    parameter int TICK_W   = qtick_pkg::TICK_W,
    parameter int CMP_W    = qtick_pkg::CMP_W,
    parameter int SCALE_SH = qtick_pkg::SCALE_SH,
    parameter int GUARD    = qtick_pkg::GUARD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              cmp_we,
    input  logic [CMP_W-1:0]  cmp_wdata,
    input  logic              irq_ack,
    output logic [CMP_W-1:0]  count_o,
    output logic [TICK_W-1:0] deadline_o,
    output logic              irq_o
);
    logic [TICK_W-1:0] tick_w;
    logic [TICK_W-1:0] next_deadline_w;
    logic              hit_w;

    qtick_counter #(
        .TICK_W(TICK_W), .CMP_W(CMP_W), .SCALE_SH(SCALE_SH)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
        .tick(tick_w), .snap(count_o)
    );

    qtick_deadline_calc #(
        .TICK_W(TICK_W), .CMP_W(CMP_W), .SCALE_SH(SCALE_SH), .GUARD(GUARD)
    ) u_calc (
        .tick(tick_w), .wdata(cmp_wdata), .deadline(next_deadline_w)
    );

    qtick_alarm #(
        .TICK_W(TICK_W)
    ) u_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick_w),
        .cmp_we(cmp_we), .new_deadline(next_deadline_w), .irq_ack(irq_ack),
        .deadline(deadline_o), .irq(irq_o), .hit(hit_w)
    );
endmodule

// File: rtl/qtick_checker.sv
// Module qtick_checker
// Temporal properties of the interval timer, bound to its top module.
// Assumes default package sizing (32-bit compare, shift by two).
module qtick_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_stb,
    input logic        cmp_we,
    input logic [31:0] cmp_wdata,
    input logic        irq_ack,
    input logic [31:0] count_o,
    input logic [63:0] deadline_o,
    input logic        irq_o,
    input logic [63:0] tick,
    input logic        hit
);
    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tick == $past(tick) + 64'd1);

    a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> count_o == $past(tick[33:2]));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(count_o));

    a_r4_splice: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> (deadline_o[33:2] == $past(cmp_wdata)) && (deadline_o[1:0] == 2'b00));

    a_r5_guard_lead: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> {1'b0, deadline_o} >= ({1'b0, $past(tick)} + 65'd1000));

    a_r7_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_we) |=> irq_o);

    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(hit));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !cmp_we && !hit) |=> !irq_o);

    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !irq_o);
endmodule

bind qtick_interval_timer qtick_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .irq_ack(irq_ack), .count_o(count_o),
    .deadline_o(deadline_o), .irq_o(irq_o), .tick(tick_w), .hit(hit_w)
);

// File: tb/qtick_interval_timer_tb.sv
// Scoreboard bench: driver tasks queue expected port values, a monitor
// process pops and compares them against the live outputs.
module qtick_interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        cmp_we = 1'b0;
    logic [31:0] cmp_wdata = '0;
    logic        irq_ack = 1'b0;
    logic [31:0] count_o;
    logic [63:0] deadline_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] ref_tick;   // bench model of elapsed ticks

    int          q_kind[$];  // 0 count, 1 deadline, 2 irq
    logic [63:0] q_val[$];
    string       q_req[$];
    event        chk_ev;

    always #2.5 clk = ~clk;  // 200 MHz

    qtick_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .irq_ack(irq_ack), .count_o(count_o),
        .deadline_o(deadline_o), .irq_o(irq_o)
    );

    // Reference tick: zero in reset, one per edge afterwards (R2).
    always @(posedge clk) begin
        if (!rst_n) ref_tick <= 64'd0;
        else        ref_tick <= ref_tick + 64'd1;
    end

    function automatic logic [63:0] model_deadline(logic [63:0] t, logic [31:0] v);
        logic [63:0] s;
        s = {t[63:34], v, 2'b00};
        if ({1'b0, s} < ({1'b0, t} + 65'd1000)) s = s + 64'h4_0000_0000;
        return s;
    endfunction

    task automatic expect_item(int kind, logic [63:0] val, string req);
        q_kind.push_back(kind);
        q_val.push_back(val);
        q_req.push_back(req);
        -> chk_ev;
    endtask

    // Monitor: pop every queued expectation and compare with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (q_kind.size() > 0) begin
                int          k;
                logic [63:0] e;
                logic [63:0] a;
                string       r;
                k = q_kind.pop_front();
                e = q_val.pop_front();
                r = q_req.pop_front();
                case (k)
                    0:       a = {32'd0, count_o};
                    1:       a = deadline_o;
                    default: a = {63'd0, irq_o};
                endcase
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", r, a, e);
                end
            end
        end
    end

    task automatic write_cmp(logic [31:0] v, output logic [63:0] exp_d);
        cmp_we    = 1'b1;
        cmp_wdata = v;
        exp_d     = model_deadline(ref_tick, v);
        @(negedge clk);
        cmp_we    = 1'b0;
    endtask

    task automatic wait_tick(logic [63:0] t);
        while (ref_tick != t) @(negedge clk);
    endtask

    task automatic wait_aligned();
        while (ref_tick[1:0] != 2'b00) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] t;
        logic [31:0] snap;

        repeat (4) @(negedge clk);
        expect_item(0, 64'd0, "R1 count in reset");
        expect_item(1, 64'd0, "R1 deadline in reset");
        expect_item(2, 64'd0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_item(2, 64'd0, "R1 irq after release");

        // R6: disarmed, the tick passes deadline 0 region and beyond
        repeat (1500) @(negedge clk);
        expect_item(2, 64'd0, "R6 no irq before first write");

        // R3: capture and hold
        t = ref_tick;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        snap = t[33:2];
        expect_item(0, {32'd0, snap}, "R3 capture");
        repeat (9) @(negedge clk);
        expect_item(0, {32'd0, snap}, "R3 hold without strobe");
        t = ref_tick;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        expect_item(0, {32'd0, 32'(t[33:2])}, "R3 second capture");

        // R4: plain write well ahead
        write_cmp(32'((ref_tick + 64'd1200) >> 2), d);
        expect_item(1, d, "R4 deadline splice");

        // R7: fire exactly one cycle after the hit cycle
        wait_tick(d);
        expect_item(2, 64'd0, "R7 irq low in hit cycle");
        @(negedge clk);
        expect_item(2, 64'd1, "R7 irq raised");
        repeat (20) @(negedge clk);
        expect_item(2, 64'd1, "R7 irq level held");

        // R8: acknowledge alone
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        expect_item(2, 64'd0, "R8 ack clears");

        // R5: guard boundary, exact lead of 1000 is kept
        wait_aligned();
        t = ref_tick;
        write_cmp(32'((t + 64'd1000) >> 2), d);
        expect_item(1, t + 64'd1000, "R5 boundary no wrap");
        wait_aligned();
        t = ref_tick;
        write_cmp(32'((t + 64'd996) >> 2), d);
        expect_item(1, t + 64'd996 + 64'h4_0000_0000, "R5 just inside guard wraps");
        t = ref_tick;
        write_cmp(32'd0, d);
        expect_item(1, 64'h4_0000_0000, "R5 zero value wraps");

        // R10: hit and ack in the same cycle
        write_cmp(32'((ref_tick + 64'd1100) >> 2), d);
        expect_item(1, d, "R4 deadline before R10");
        wait_tick(d);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        expect_item(2, 64'd1, "R10 hit beats ack");

        // R9: write clears a pending irq
        write_cmp(32'((ref_tick + 64'd1300) >> 2), d);
        expect_item(2, 64'd0, "R9 write clears irq");
        expect_item(1, d, "R9 new deadline stored");

        // R9: write in the hit cycle wins over the hit
        wait_tick(d);
        write_cmp(32'((ref_tick + 64'd2000) >> 2), d);
        expect_item(2, 64'd0, "R9 write beats hit");
        expect_item(1, d, "R9 deadline after coincident write");
        wait_tick(d);
        @(negedge clk);
        expect_item(2, 64'd1, "R7 rearmed alarm fires");

        #1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule